// File: doc/BRIEF.md
# Pointer-Addressed Serial-Bus Register Slave

This block is the digital half of a two-wire serial-bus slave that lets a bus master read and write a small bank of 16-bit registers. A write-only 8-bit pointer selects a register. Every transfer begins with an address byte. In a write transfer, the first data byte loads the pointer and the next two bytes form a 16-bit word, high byte first. A read transfer returns the selected word, high byte first. A master can read from the pointer it set earlier, or it can set the pointer and then switch to reading through a repeated start.

SCL and SDA are sampled with the system clock after a synchroniser. The block drives SDA low through an open-drain enable. The register contents come in on a flat bus. Completed word writes leave as a one-cycle strobe that carries the pointer and the data. The 7-bit bus address has a fixed upper nibble of binary 0011. Its lower three bits come from strap inputs, which are frozen during the second transfer that addresses the block. If SDA stays still for too long, the slave releases the line and waits for a new start condition.

The write strobe is a valid-only stream. The bus cannot be stalled, so there is no ready and no back-pressure. The consumer must take each strobe in the cycle it is high.

Top module: `smb_reg_slave`

## Requirements
- R1: The slave answers address `{4'b0011, strap}`. It acknowledges by driving SDA low (sda_oe_o=1) during the ninth SCL clock of a matching address byte. On any other address it never drives SDA, and it ignores the rest of the transfer until the next start.
- R2: In a write transfer, the first byte after the address loads the pointer, which is visible on ptr_o. The pointer resets to 0x00 and keeps its value across transfers. A write that carries only the pointer produces no write strobe.
- R3: The two bytes after the pointer byte form one word, with the first byte as bits 15:8. When the second byte completes, wr_valid_o is high for exactly one cycle, and wr_ptr_o equals the pointer and wr_data_o equals the word.
- R4: A word write produces a strobe only when the pointer is below NREG and its bit in WR_MASK is set. With the default mask 8'b0001_1110, only pointers 1 to 4 are writable. Writes to any other pointer, including 0x08 and above, produce no strobe.
- R5: Data bytes after the second data byte are acknowledged but ignored. They produce no further strobe and leave the pointer unchanged.
- R6: A read transfer returns the word at regs_i[16*ptr +: 16] for pointers below NREG, and 0 for all other pointers. The high byte comes first and each byte is sent MSB first. The master may NACK after either byte. Any byte read after the second one reads as 0xFF.
- R7: After a pointer write, a repeated start followed by a read address returns the word at the newly written pointer.
- R8: Until latched, the low address bits follow strap_i. They are latched from strap_i when the eighth address bit of the second matching transfer is evaluated. After that, changes on strap_i have no effect on addr_o or on which address is acknowledged.
- R9: If the slave is not idle and SDA shows no edge for TIMEOUT_CYC clock cycles, it releases SDA and ignores the bus until the next start. It then accepts a new transfer normally.
- R10: sda_oe_o changes only while the synchronised SCL is low, and it is low whenever the slave is idle.
- R11: After reset, sda_oe_o is 0, ptr_o is 0x00 and wr_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| strap_i | input | 3 | Low address bits from the strap pins |
| regs_i | input | NREG*16 | Register contents, with word k at bits 16k+15:16k |
| ptr_o | output | 8 | Current pointer value |
| rd_stb_o | output | 1 | One-cycle pulse when a read word is fetched at ptr_o |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_ptr_o | output | 8 | Pointer of the word write |
| wr_data_o | output | 16 | Data of the word write |
| addr_o | output | 7 | Bus address currently answered |

## Verification
A bit counter that is off by one clock moves the acknowledge into the wrong SCL period. The master's ninth-clock sample of that same byte catches this, and the read data then comes back shifted by one bit. A corrupted pointer shows on ptr_o as soon as the pointer byte ends, and again in the next word read. A strap latch that freezes too early or too late shows on the next transfer after the strap inputs change: the wrong address is acknowledged. A timeout counter that never expires leaves SDA held low long after TIMEOUT_CYC cycles have passed.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;
  localparam logic [3:0] ADDR_HI = 4'b0011;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_edge
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_ff, sda_ff;
  logic         scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[TOP-1:0], scl_i};
      sda_ff <= {sda_ff[TOP-1:0], sda_i};
      scl_p  <= scl_ff[TOP];
      sda_p  <= sda_ff[TOP];
    end
  end

  assign scl_s     = scl_ff[TOP];
  assign sda_s     = sda_ff[TOP];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign sda_edge  = sda_s ^ sda_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_addr_strap.sv
module smb_addr_strap #(
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               match_evt,
  output logic [STRAP_W-1:0] addr_lsb,
  output logic               locked
);
  logic               seen;
  logic [STRAP_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      locked <= 1'b0;
      held   <= '0;
    end else if (match_evt && !locked) begin
      if (seen) begin
        locked <= 1'b1;
        held   <= strap_i;
      end else begin
        seen <= 1'b1;
      end
    end
  end

  assign addr_lsb = locked ? held : strap_i;
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic sda_edge,
  output logic expired
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign expired = active && !sda_edge && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active || sda_edge || expired) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_reg_pkg::*;
#(
  parameter int              NREG        = 8,
  parameter int              REG_W       = 16,
  parameter logic [NREG-1:0] WR_MASK     = 8'b0001_1110,
  parameter int              TIMEOUT_CYC = 15_000_000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [2:0]            strap_i,
  input  logic [NREG*REG_W-1:0] regs_i,
  output logic [7:0]            ptr_o,
  output logic                  rd_stb_o,
  output logic                  wr_valid_o,
  output logic [7:0]            wr_ptr_o,
  output logic [REG_W-1:0]      wr_data_o,
  output logic [6:0]            addr_o
);
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);
  localparam logic [3:0] ACK_BIT  = 4'(BYTE_BITS + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt, sda_edge;
  logic tmo, match_evt, addr_locked, addr_hit, slv_idle, writable;
  logic [2:0] addr_lsb;

  slv_state_e       state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [REG_W-1:0] tx;
  logic [1:0]       byte_idx;
  logic [7:0]       ptr, hi;
  logic             mnack;
  logic [REG_W-1:0] rd_word;
  logic [REG_W-1:0] bank [NREG];

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_edge(sda_edge)
  );

  smb_addr_strap #(.STRAP_W(3)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .match_evt(match_evt),
    .addr_lsb(addr_lsb), .locked(addr_locked)
  );

  smb_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(!slv_idle), .sda_edge(sda_edge),
    .expired(tmo)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    assign bank[g] = regs_i[g*REG_W +: REG_W];
  end

  assign addr_o    = {ADDR_HI, addr_lsb};
  assign addr_hit  = (shreg[7:1] == addr_o);
  assign slv_idle  = (state == ST_IDLE);
  assign match_evt = !tmo && scl_fall && (state == ST_ADDR) &&
                     (bitcnt == LAST_BIT) && addr_hit;
  assign rd_word   = (32'(ptr) < NREG) ? bank[ptr[IDXW-1:0]] : '0;
  assign writable  = (32'(ptr) < NREG) && WR_MASK[ptr[IDXW-1:0]];
  assign ptr_o     = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      tx         <= '1;
      byte_idx   <= '0;
      ptr        <= '0;
      hi         <= '0;
      mnack      <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_ptr_o   <= '0;
      wr_data_o  <= '0;
      rd_stb_o   <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_stb_o   <= 1'b0;
      if (tmo) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_evt) begin
        state    <= ST_ADDR;
        bitcnt   <= '0;
        byte_idx <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_evt) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (scl_rise) begin
        if (state == ST_ADDR || state == ST_WRITE || state == ST_READ) begin
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt < LAST_BIT && state != ST_READ)
            shreg <= {shreg[6:0], sda_s};
          if (bitcnt == LAST_BIT && state == ST_READ)
            mnack <= sda_s;
        end
      end else if (scl_fall) begin
        case (state)
          ST_ADDR: begin
            if (bitcnt == LAST_BIT) begin
              if (addr_hit) sda_oe_o <= 1'b1;
              else          state    <= ST_SKIP;
            end else if (bitcnt == ACK_BIT) begin
              bitcnt <= '0;
              if (shreg[0]) begin
                state    <= ST_READ;
                sda_oe_o <= ~rd_word[REG_W-1];
                tx       <= {rd_word[REG_W-2:0], 1'b1};
                rd_stb_o <= 1'b1;
              end else begin
                state    <= ST_WRITE;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_WRITE: begin
            if (bitcnt == LAST_BIT) begin
              sda_oe_o <= 1'b1;
              case (byte_idx)
                2'd0: ptr <= shreg;
                2'd1: hi  <= shreg;
                2'd2: begin
                  if (writable) begin
                    wr_valid_o <= 1'b1;
                    wr_ptr_o   <= ptr;
                    wr_data_o  <= {hi, shreg};
                  end
                end
                default: ;
              endcase
              if (byte_idx != 2'd3) byte_idx <= byte_idx + 1'b1;
            end else if (bitcnt == ACK_BIT) begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
            end
          end
          ST_READ: begin
            if (bitcnt >= 4'd1 && bitcnt < LAST_BIT) begin
              sda_oe_o <= ~tx[REG_W-1];
              tx       <= {tx[REG_W-2:0], 1'b1};
            end else if (bitcnt == LAST_BIT) begin
              sda_oe_o <= 1'b0;
            end else if (bitcnt == ACK_BIT) begin
              bitcnt <= '0;
              if (mnack) begin
                state    <= ST_SKIP;
                sda_oe_o <= 1'b0;
              end else begin
                sda_oe_o <= ~tx[REG_W-1];
                tx       <= {tx[REG_W-2:0], 1'b1};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int              NREG    = 8,
  parameter logic [NREG-1:0] WR_MASK = 8'b0001_1110
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe_o,
  input logic       wr_valid_o,
  input logic [7:0] wr_ptr_o,
  input logic [7:0] ptr_o,
  input logic [6:0] addr_o,
  input logic       addr_locked,
  input logic       slv_idle
);
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o); // R3

  AST_WR_PTR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_ptr_o == ptr_o)); // R3

  AST_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> ((32'(wr_ptr_o) < NREG) && WR_MASK[wr_ptr_o[IDXW-1:0]])); // R4

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_locked && $past(addr_locked)) |-> $stable(addr_o)); // R8

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    slv_idle |-> !sda_oe_o); // R9

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s); // R10
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.NREG(NREG), .WR_MASK(WR_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .wr_valid_o(wr_valid_o), .wr_ptr_o(wr_ptr_o), .ptr_o(ptr_o),
  .addr_o(addr_o), .addr_locked(addr_locked), .slv_idle(slv_idle)
);

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;
  localparam int NREG = 8;
  localparam int TMO  = 3000;
  localparam int Q    = 10;
  localparam logic [7:0] MASK = 8'b0001_1110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  logic [2:0] strap;
  logic [NREG*16-1:0] regs;
  logic [7:0] ptr_o, wr_ptr;
  logic rd_stb, wr_valid;
  logic [15:0] wr_data;
  logic [6:0] addr_o;

  assign sda_line = m_sda & ~sda_oe;

  smb_reg_slave #(.NREG(NREG), .WR_MASK(MASK), .TIMEOUT_CYC(TMO)) i_smb_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .regs_i(regs), .ptr_o(ptr_o), .rd_stb_o(rd_stb),
    .wr_valid_o(wr_valid), .wr_ptr_o(wr_ptr), .wr_data_o(wr_data), .addr_o(addr_o)
  );

  int total = 0, bad = 0, wr_cnt = 0;
  logic [7:0]  last_ptr;
  logic [15:0] last_data;
  bit done = 0;

  always @(negedge clk) if (wr_valid) begin
    wr_cnt++;
    last_ptr  = wr_ptr;
    last_data = wr_data;
  end

  function automatic logic [15:0] exp_word(int i);
    return 16'((i + 1) * 32'h1357) ^ 16'h2468;
  endfunction

  function automatic bit exp_wr(int p);
    return (p < NREG) && MASK[p];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; hw(Q);
    m_scl = 1'b1; hw(2*Q);
    m_sda = 1'b0; hw(2*Q);
    m_scl = 1'b0; hw(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; hw(Q);
    m_scl = 1'b1; hw(2*Q);
    m_sda = 1'b1; hw(4*Q);
  endtask

  task automatic bit_out(bit b);
    m_sda = b; hw(Q);
    m_scl = 1'b1; hw(2*Q);
    m_scl = 1'b0; hw(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    m_sda = 1'b1; hw(Q);
    m_scl = 1'b1; hw(Q);
    ack = !sda_line; hw(Q);
    m_scl = 1'b0; hw(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(Q); m_scl = 1'b1; hw(Q);
      b[i] = sda_line; hw(Q);
      m_scl = 1'b0; hw(Q);
    end
    bit_out(nack);
    m_sda = 1'b1;
  endtask

  // n data bytes after the address, taken from bs[39:32], bs[31:24], ...
  task automatic wr(input logic [6:0] a, input int n, input logic [39:0] bs,
                    output bit aack, output bit dack);
    bit k;
    m_start();
    send_byte({a, 1'b0}, aack);
    dack = 1'b1;
    for (int i = 0; i < n; i++) begin
      send_byte(bs[39-8*i -: 8], k);
      dack &= k;
    end
    m_stop();
  endtask

  task automatic rd(input logic [6:0] a, input bit use_ptr, input logic [7:0] p,
                    input int nb, output logic [23:0] d, output bit aack);
    bit k1, k2, k3;
    logic [7:0] b;
    k1 = 1'b1; k2 = 1'b1;
    m_start();
    if (use_ptr) begin
      send_byte({a, 1'b0}, k1);
      send_byte(p, k2);
      m_start();
    end
    send_byte({a, 1'b1}, k3);
    aack = k1 & k2 & k3;
    d = '0;
    for (int i = 0; i < nb; i++) begin
      recv_byte(b, i == nb - 1);
      d = {d[15:0], b};
    end
    m_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit aa, da;
    logic [23:0] d;
    int c0;
    logic [15:0] wd;
    strap = 3'b101;
    for (int i = 0; i < NREG; i++) regs[i*16 +: 16] = exp_word(i);
    hw(10);
    chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    chk(ptr_o == 8'h00, "R11 pointer", ptr_o, 0);
    chk(wr_valid == 1'b0, "R11 strobe", wr_valid, 0);
    rst_n = 1'b1;
    hw(10);
    chk(addr_o == 7'h1D, "R8 live strap", addr_o, 7'h1D);

    // pointer-only write
    wr(7'h1D, 1, {8'h01, 32'h0}, aa, da);
    chk(aa, "R1 address ack", aa, 1);
    chk(ptr_o == 8'h01, "R2 pointer loaded", ptr_o, 1);
    chk(wr_cnt == 0, "R2 no strobe on pointer write", wr_cnt, 0);

    // wrong address is ignored
    wr(7'h1C, 1, {8'h05, 32'h0}, aa, da);
    chk(!aa, "R1 mismatch not acked", aa, 0);
    chk(ptr_o == 8'h01, "R1 mismatch leaves pointer", ptr_o, 1);

    // word write, second matching transfer latches straps
    wr(7'h1D, 3, {8'h02, 8'hAB, 8'hCD, 16'h0}, aa, da);
    chk(wr_cnt == 1, "R3 one strobe", wr_cnt, 1);
    chk(last_ptr == 8'h02, "R3 strobe pointer", last_ptr, 2);
    chk(last_data == 16'hABCD, "R3 strobe data", last_data, 16'hABCD);

    strap = 3'b010;
    hw(4);
    chk(addr_o == 7'h1D, "R8 address frozen", addr_o, 7'h1D);
    wr(7'h1A, 0, 40'h0, aa, da);
    chk(!aa, "R8 new strap not answered", aa, 0);
    wr(7'h1D, 0, 40'h0, aa, da);
    chk(aa, "R8 latched address answered", aa, 1);

    // read from preset pointer
    rd(7'h1D, 1'b0, 8'h00, 2, d, aa);
    chk(d[15:0] == exp_word(2), "R2 read at kept pointer", d[15:0], exp_word(2));

    // pointer sweep with repeated start
    for (int p = 0; p < 10; p++) begin
      rd(7'h1D, 1'b1, 8'(p), 2, d, aa);
      wd = (p < NREG) ? exp_word(p) : 16'h0000;
      chk(aa, "R7 acks", aa, 1);
      chk(d[15:0] == wd, "R6 R7 read word", d[15:0], wd);
      chk(ptr_o == 8'(p), "R2 pointer after read", ptr_o, p);
    end

    // bytes beyond two
    rd(7'h1D, 1'b1, 8'h05, 3, d, aa);
    chk(d == {exp_word(5), 8'hFF}, "R6 third byte reads FF", d, {exp_word(5), 8'hFF});

    // write sweep over writability mask
    for (int p = 0; p < 10; p++) begin
      wd = 16'(p * 16'h1111) ^ 16'h5A5A;
      c0 = wr_cnt;
      wr(7'h1D, 3, {8'(p), wd, 16'h0}, aa, da);
      chk((wr_cnt - c0) == int'(exp_wr(p)), "R4 strobe only when writable", wr_cnt - c0, exp_wr(p));
      if (exp_wr(p)) begin
        chk(last_ptr == 8'(p) && last_data == wd, "R3 sweep strobe", last_data, wd);
      end
    end

    // surplus bytes
    c0 = wr_cnt;
    wr(7'h1D, 5, {8'h03, 8'h12, 8'h34, 8'h56, 8'h78}, aa, da);
    chk(da, "R5 surplus bytes acked", da, 1);
    chk(wr_cnt - c0 == 1, "R5 single strobe", wr_cnt - c0, 1);
    chk(last_data == 16'h1234, "R5 first word kept", last_data, 16'h1234);
    chk(ptr_o == 8'h03, "R5 pointer unchanged", ptr_o, 3);

    // timeout: pointer 9 reads 0, so slave drives its first bit low
    wr(7'h1D, 1, {8'h09, 32'h0}, aa, da);
    m_start();
    send_byte({7'h1D, 1'b1}, aa);
    hw(3*Q);
    chk(sda_oe == 1'b1, "R9 slave driving before timeout", sda_oe, 1);
    hw(TMO + 100);
    chk(sda_oe == 1'b0, "R9 released after timeout", sda_oe, 0);
    wr(7'h1D, 1, {8'h04, 32'h0}, aa, da);
    chk(aa, "R9 new transfer accepted", aa, 1);
    chk(ptr_o == 8'h04, "R9 pointer after recovery", ptr_o, 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule